// File: doc/BRIEF.md
# Bit-Serial Configuration Store Reader

This block is the read side of a one-bit-wide configuration memory that loads an FPGA at power-up. A bit-addressed store is filled through a simple parallel write port. It is then read out one bit per rising edge of the configuration clock that the loading FPGA drives. The default build is a small store. Production builds set `DEPTH` to 65536, 131072 or 262144 bits, and the address counter width follows as ceil(log2(DEPTH)).

Three plain inputs control the read. A chip-select input gates the address counter and the output. A serial-enable input must be high for the read logic to work. A combined reset/output-enable input clears the address counter when it sits at its reset level. A stored polarity bit picks that level, so the pin can be wired straight to either sense of the FPGA's reset without an inverter. When the last bit has gone out, the block raises a cascade output that drives the chip-select of the next store in a chain. The whole chain therefore delivers one continuous stream.

The serial output is a stream with a valid flag and no ready. The block cannot apply back-pressure. A consumer pauses the stream only by holding back clock edges, by dropping chip-select, or by dropping serial-enable. Every enabled edge consumes exactly one bit.

Top module: `cfgmem_serial_reader`

## Requirements
- R1: With serial-enable high, chip-select high and reset inactive, `sdata` shows the stored bit at the counter's address. Bits go out in ascending address order, one per rising `cclk`, and bit 0 is already visible before the first edge after a reset.
- R2: The address counter advances by exactly one on a rising `cclk` only when `ser_en`, `chip_en` and the inactive reset level all hold and the store is not yet exhausted.
- R3: When `oe_rst` is at its reset level on a rising edge, the counter clears to 0 and the exhausted state clears, even if chip-select is high on that edge. The next bit shown is bit 0.
- R4: The polarity bit is loaded from `pol_val` on an edge with `pol_wr` high. With polarity 1, `oe_rst` high is reset and low enables output. With polarity 0 the sense is reversed.
- R5: `sdata_vld` is high exactly when `ser_en`, `chip_en` and the inactive reset level hold and the store is not exhausted. `sdata` reads 0 whenever `sdata_vld` is low.
- R6: The edge that consumes bit DEPTH-1 sets the exhausted state. From then on `sdata_vld` stays low and the counter does not wrap. `casc_en` is high whenever chip-select and serial-enable are high and reset is inactive, until the next reset.
- R7: `casc_en` is low whenever `chip_en` is low, `ser_en` is low or reset is active, and it is never high together with `sdata_vld`.
- R8: With `ser_en` low, edges leave the counter unchanged and `sdata_vld` and `casc_en` stay low. On return, reading resumes at the same bit.
- R9: An edge with `mem_wr` high stores `mem_wdata` at `mem_waddr`. Writes are accepted during a read and show up on `sdata` once the counter reaches that address.
- R10: Two stores, with the second's `chip_en` driven by the first's `casc_en`, deliver 2*DEPTH bits with no gap: the second store's bit 0 is valid in the cycle after the first store's last bit.
- R11: `por_n` low on an edge clears the counter and the exhausted state and sets the polarity bit to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock from the loading FPGA |
| por_n | input | 1 | Power-on reset, active low, sampled on `cclk` |
| ser_en | input | 1 | Serial read enable, high for normal operation |
| chip_en | input | 1 | Chip-select, active high; driven by the previous store's `casc_en` in a chain |
| oe_rst | input | 1 | Combined output-enable / counter reset; the polarity bit picks which level is reset |
| pol_wr | input | 1 | Load strobe for the polarity bit |
| pol_val | input | 1 | New polarity: 1 means high is reset, 0 means low is reset |
| mem_wr | input | 1 | Store write strobe |
| mem_waddr | input | $clog2(DEPTH) | Store write bit address |
| mem_wdata | input | 1 | Store write data bit |
| sdata | output | 1 | Serial data bit |
| sdata_vld | output | 1 | `sdata` carries a live bit (stands in for the high-impedance state when low) |
| casc_en | output | 1 | Cascade enable to the next store's `chip_en` |

## Verification
The assertions assume that `por_n` is held low for at least one `cclk` edge before any read, and that `mem_waddr` stays below DEPTH. The bench keeps to both by pulsing `por_n` for several edges at the start and by sweeping write addresses only over 0..DEPTH-1. They also assume that every input changes away from the rising edge. The bench drives all inputs just after the falling edge and samples shortly after, in the same half period. In the chained pair, the second store's chip-select is always the first store's cascade output, never a free bench signal.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

  // Level the polarity bit takes after power-on reset: oe_rst high means reset.
  localparam logic POL_AFTER_POR = 1'b1;

  // Per-edge command from the control decoder to the address counter.
  typedef struct packed {
    logic clear;  // reset level present on oe_rst
    logic step;   // enabled read edge (ser_en, chip_en, reset inactive, out of POR)
  } ctr_cmd_t;

endpackage

// File: rtl/cfgmem_ctrl.sv
module cfgmem_ctrl
  import cfgmem_pkg::*;
(
  input  logic     cclk,
  input  logic     por_n,
  input  logic     ser_en,
  input  logic     chip_en,
  input  logic     oe_rst,
  input  logic     pol_wr,
  input  logic     pol_val,
  output ctr_cmd_t cmd
);

  logic pol_q;
  logic rst_level;

  always_ff @(posedge cclk) begin
    if (!por_n)      pol_q <= POL_AFTER_POR;
    else if (pol_wr) pol_q <= pol_val;
  end

  // The pin is at its reset level when it matches the programmed polarity.
  assign rst_level = (oe_rst == pol_q);

  always_comb begin
    cmd.clear = rst_level;
    cmd.step  = por_n & ser_en & chip_en & ~rst_level;
  end

  AST_POL_LOAD: assert property (@(posedge cclk) disable iff (!por_n)
    pol_wr |=> (pol_q == $past(pol_val))); // R4

  AST_STEP_NEEDS_ENABLES: assert property (@(posedge cclk) disable iff (!por_n)
    cmd.step |-> (ser_en && chip_en && !cmd.clear)); // R2

endmodule

// File: rtl/cfgmem_addr_ctr.sv
module cfgmem_addr_ctr
  import cfgmem_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          cclk,
  input  logic          por_n,
  input  ctr_cmd_t      cmd,
  output logic [AW-1:0] addr,
  output logic          exhausted
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic at_last;
  assign at_last = (addr == LAST);

  // Reset wins over clocking; the counter parks on LAST instead of wrapping.
  always_ff @(posedge cclk) begin
    if (!por_n || cmd.clear) begin
      addr      <= '0;
      exhausted <= 1'b0;
    end else if (cmd.step && !exhausted) begin
      if (at_last) exhausted <= 1'b1;
      else         addr      <= addr + 1'b1;
    end
  end

  AST_CLEAR_ZEROES: assert property (@(posedge cclk) disable iff (!por_n)
    cmd.clear |=> (addr == '0 && !exhausted)); // R3

  AST_STEP_ADVANCES: assert property (@(posedge cclk) disable iff (!por_n)
    (cmd.step && !cmd.clear && !exhausted && !at_last) |=> (addr == $past(addr) + 1'b1)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge cclk) disable iff (!por_n)
    (!cmd.step && !cmd.clear) |=> (addr == $past(addr) && exhausted == $past(exhausted))); // R8

  AST_EXHAUST_STICKY: assert property (@(posedge cclk) disable iff (!por_n)
    (exhausted && !cmd.clear) |=> exhausted); // R6

  AST_NO_WRAP: assert property (@(posedge cclk) disable iff (!por_n)
    exhausted |-> at_last); // R6

endmodule

// File: rtl/cfgmem_store.sv
module cfgmem_store #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          cclk,
  input  logic          por_n,
  input  logic          wr,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);

  logic mem_q [DEPTH];

  always_ff @(posedge cclk) begin
    if (wr) mem_q[waddr] <= wdata;
  end

  // Asynchronous bit select: the new bit follows the counter right after the edge.
  assign rdata = mem_q[raddr];

  AST_WRITE_LANDS: assert property (@(posedge cclk) disable iff (!por_n)
    wr |=> (mem_q[$past(waddr)] == $past(wdata))); // R9

endmodule

// File: rtl/cfgmem_serial_reader.sv
module cfgmem_serial_reader
  import cfgmem_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          cclk,
  input  logic          por_n,
  input  logic          ser_en,
  input  logic          chip_en,
  input  logic          oe_rst,
  input  logic          pol_wr,
  input  logic          pol_val,
  input  logic          mem_wr,
  input  logic [AW-1:0] mem_waddr,
  input  logic          mem_wdata,
  output logic          sdata,
  output logic          sdata_vld,
  output logic          casc_en
);

  ctr_cmd_t      cmd;
  logic [AW-1:0] rd_addr;
  logic          exhausted;
  logic          rd_bit;

  cfgmem_ctrl u_ctrl (
    .cclk    (cclk),
    .por_n   (por_n),
    .ser_en  (ser_en),
    .chip_en (chip_en),
    .oe_rst  (oe_rst),
    .pol_wr  (pol_wr),
    .pol_val (pol_val),
    .cmd     (cmd)
  );

  cfgmem_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .cclk      (cclk),
    .por_n     (por_n),
    .cmd       (cmd),
    .addr      (rd_addr),
    .exhausted (exhausted)
  );

  cfgmem_store #(.DEPTH(DEPTH)) u_store (
    .cclk  (cclk),
    .por_n (por_n),
    .wr    (mem_wr),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (rd_addr),
    .rdata (rd_bit)
  );

  assign sdata_vld = cmd.step & ~exhausted;
  assign sdata     = sdata_vld & rd_bit;
  assign casc_en   = cmd.step & exhausted;

  AST_VLD_CASC_EXCL: assert property (@(posedge cclk) disable iff (!por_n)
    !(sdata_vld && casc_en)); // R7

  AST_CASC_NEEDS_SELECT: assert property (@(posedge cclk) disable iff (!por_n)
    casc_en |-> (chip_en && ser_en)); // R7

  AST_QUIET_DATA: assert property (@(posedge cclk) disable iff (!por_n)
    !sdata_vld |-> !sdata); // R5

endmodule

// File: tb/tb_cfgmem_serial_reader.sv
module tb_cfgmem_serial_reader;

  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);

  logic cclk = 1'b0;
  always #10 cclk = ~cclk;  // 50 MHz

  logic por_n = 1'b0, ser_en = 1'b0, chip_en = 1'b0, oe_rst = 1'b0;
  logic pol_wr = 1'b0, pol_val = 1'b0;
  logic wr0 = 1'b0, wd0 = 1'b0, wr1 = 1'b0, wd1 = 1'b0;
  logic [AW-1:0] wa0 = '0, wa1 = '0;
  logic sd0, v0, c0, sd1, v1, c1;

  bit m0 [DEPTH];
  bit m1 [DEPTH];
  int n_tests = 0;
  int n_fail  = 0;

  cfgmem_serial_reader #(.DEPTH(DEPTH)) dut (
    .cclk(cclk), .por_n(por_n), .ser_en(ser_en), .chip_en(chip_en), .oe_rst(oe_rst),
    .pol_wr(pol_wr), .pol_val(pol_val), .mem_wr(wr0), .mem_waddr(wa0), .mem_wdata(wd0),
    .sdata(sd0), .sdata_vld(v0), .casc_en(c0));

  cfgmem_serial_reader #(.DEPTH(DEPTH)) dut2 (
    .cclk(cclk), .por_n(por_n), .ser_en(ser_en), .chip_en(c0), .oe_rst(oe_rst),
    .pol_wr(pol_wr), .pol_val(pol_val), .mem_wr(wr1), .mem_waddr(wa1), .mem_wdata(wd1),
    .sdata(sd1), .sdata_vld(v1), .casc_en(c1));

  function automatic bit pat0(int k);
    return bit'((((k * 5 + 3) >> 2) ^ k) & 1);
  endfunction

  function automatic bit pat1(int k);
    return bit'((((k * 7) >> 1) ^ (k >> 3) ^ 1) & 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One rising edge, then land just after the falling edge.
  task automatic tick();
    @(negedge cclk);
    #2;
  endtask

  task automatic settle();
    #1;
  endtask

  // Full read of the chained pair from bit 0 of the first store.
  task automatic run_chain();
    for (int k = 0; k < DEPTH; k++) begin
      chk("R1 first store bit", sd0, m0[k]);
      chk("R5 first store valid", v0, 1);
      chk("R7 no cascade mid-read", c0, 0);
      chk("R10 second idle", v1, 0);
      tick();
    end
    chk("R6 first exhausted valid low", v0, 0);
    chk("R6 first cascade high", c0, 1);
    for (int k = 0; k < DEPTH; k++) begin
      chk("R10 second store bit", sd1, m1[k]);
      chk("R10 second valid", v1, 1);
      chk("R6 first stays exhausted", v0, 0);
      tick();
    end
    chk("R6 second cascade high", c1, 1);
    chk("R6 second valid low", v1, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      m0[k] = pat0(k);
      m1[k] = pat1(k);
    end
    repeat (3) tick();
    por_n = 1'b1; ser_en = 1'b1; settle();
    // R11: polarity 1 after POR, oe_rst low is inactive, chip-select low
    chk("R11 reset state valid", v0, 0);
    chk("R7 reset state cascade", c0, 0);
    chk("R7 reset state cascade 2", c1, 0);
    chk("R5 quiet data", sd0, 0);

    // R9: load both stores over every address
    for (int k = 0; k < DEPTH; k++) begin
      wr0 = 1'b1; wa0 = AW'(k); wd0 = m0[k];
      wr1 = 1'b1; wa1 = AW'(k); wd1 = m1[k];
      tick();
    end
    wr0 = 1'b0; wr1 = 1'b0;

    chip_en = 1'b1; settle();
    run_chain();  // R1 R2 R6 R10
    repeat (3) tick();
    chk("R6 no wrap, cascade held", c0, 1);
    chk("R6 no wrap, valid low", v0, 0);

    chip_en = 1'b0; settle();
    chk("R7 chip-select low drops cascade", c0, 0);
    chk("R7 chained cascade drops", c1, 0);
    chip_en = 1'b1; settle();
    chk("R6 cascade back with chip-select", c0, 1);

    // R3: reset at level 1 (polarity 1)
    oe_rst = 1'b1; settle();
    chk("R7 reset drops cascade", c0, 0);
    chk("R5 reset drops valid", v0, 0);
    tick();
    oe_rst = 1'b0; settle();
    chk("R3 restart bit 0", sd0, m0[0]);
    chk("R3 restart valid", v0, 1);
    chk("R3 chained cleared", c0, 0);

    // R3: mid-stream reset with chip-select high on the reset edge
    for (int k = 0; k < 10; k++) begin
      chk("R2 mid bit", sd0, m0[k]);
      tick();
    end
    chk("R2 bit 10", sd0, m0[10]);
    oe_rst = 1'b1; tick();
    oe_rst = 1'b0; settle();
    chk("R3 mid-stream restart", sd0, m0[0]);
    for (int k = 0; k < 3; k++) begin
      chk("R3 continue after restart", sd0, m0[k]);
      tick();
    end

    // R8: serial-enable low freezes the counter
    ser_en = 1'b0; settle();
    chk("R8 valid low", v0, 0);
    chk("R8 cascade low", c0, 0);
    repeat (5) tick();
    ser_en = 1'b1; settle();
    chk("R8 resumes at bit 3", sd0, m0[3]);

    // R9: write ahead of the read pointer during a read
    m0[4] = ~m0[4];
    wr0 = 1'b1; wa0 = AW'(4); wd0 = m0[4];
    tick();
    wr0 = 1'b0; settle();
    chk("R9 written bit read back", sd0, m0[4]);

    // R4: switch to polarity 0 while oe_rst high (resets under old polarity)
    oe_rst = 1'b1; pol_wr = 1'b1; pol_val = 1'b0;
    tick();
    pol_wr = 1'b0; settle();
    chk("R4 high inactive under polarity 0", v0, 1);
    chk("R4 restart bit 0", sd0, m0[0]);
    for (int k = 0; k < 5; k++) tick();
    chk("R4 counting under polarity 0", sd0, m0[5]);
    oe_rst = 1'b0; settle();
    chk("R4 low is reset under polarity 0", v0, 0);
    tick();
    oe_rst = 1'b1; settle();
    run_chain();  // R1 R10 under polarity 0

    // R11: power-on reset restores polarity 1, so oe_rst high is reset again
    por_n = 1'b0; tick();
    por_n = 1'b1; settle();
    chk("R11 polarity back to 1", v0, 0);
    chk("R11 cascade cleared", c0, 0);
    oe_rst = 1'b0; settle();
    chk("R11 counter at 0", sd0, m0[0]);
    chk("R11 valid", v0, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule